// File: doc/BRIEF.md
# SD Command Path Controller

This block drives the command line of an SD card bus. Software presents a 6-bit command index, a 32-bit argument, a 2-bit response code and a data-transfer flag together with a one-cycle start strobe. The block builds the 48-bit command frame with its CRC7 and shifts it out at one bit per clock cycle, MSB first. If the response code asks for a response, it then waits for the card's start bit, captures a 48-bit or 136-bit response and reports the outcome through status flags. Each clock cycle of `clk_i` is one bit time of the card clock. Clock division is outside this block.

The block holds its status flags until the next accepted command. A command whose index matches the stop-transmission index produces an abort pulse toward the data path. A command marked as tied to a data transfer produces a start pulse toward the data path when it completes successfully.

Top module: `sd_cmd_path`

## Requirements
- R1: An accepted command drives `cmd_o` for 48 cycles, starting in the cycle after the start edge. The frame bits are, in order: 0, 1, the index MSB first, the argument MSB first, the CRC7 and a final 1. The CRC7 uses polynomial x^7+x^3+1 with initial value 0 and covers the first 40 frame bits. `cmd_oe_o` is high exactly during those 48 cycles. When not driving, `cmd_o` rests at 1.
- R2: Response code bit 0 selects whether a response is expected. Codes 0 and 2 mean no response: at the clock edge after the final frame bit, `sent_o` rises and `busy_o` falls. Code 1 selects a 48-bit response and code 3 selects a 136-bit response.
- R3: For a command that expects a response, `sent_o` rises after the end bit and `busy_o` stays high. It falls only together with exactly one of `resp_ok_o`, `crc_fail_o` or `timeout_o`.
- R4: After the end bit, `cmd_i` is sampled at each clock edge. If no 0 is seen within 64 samples, `timeout_o` rises at the 64th sample and the command ends. A start bit at sample 64 is still accepted. `resp_ok_o`, `crc_fail_o` and `timeout_o` are never high together. A timeout leaves the response words unchanged.
- R5: In a 48-bit response, bits 8..39 (counted from the start bit as bit 0) form the status payload. Bits 40..46 hold a CRC7 over bits 0..39. On a match, the payload goes to `resp_w0_o` and `resp_ok_o` rises. On a mismatch, `crc_fail_o` rises and all words stay unchanged.
- R6: In a 136-bit response, the 128 bits after the 8-bit header fill `resp_w0_o` (first received bits, 127:96) down to `resp_w3_o` (bits 31:0). No CRC is checked, and `resp_ok_o` always rises.
- R7: A command accepted with index 12 raises `stop_xfer_o` for exactly the one cycle after the start edge. No other index raises it.
- R8: When the data flag is set, `data_start_o` pulses for one cycle as the command completes successfully: with `sent_o` when there is no response, or with `resp_ok_o` otherwise. It does not pulse on a CRC failure or a timeout, or when the flag is clear.
- R9: A start strobe while `busy_o` is high is ignored. The frame being sent, the flags and `stop_xfer_o` are unaffected. Command fields are latched at acceptance, and an accepted start clears all status flags.
- R10: During reset, the outputs are: `busy_o` 0, `cmd_oe_o` 0, `cmd_o` 1, all flags and pulses 0, and all response words 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one card clock period per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new command |
| idx_i | input | 6 | Command index |
| arg_i | input | 32 | Command argument |
| resp_code_i | input | 2 | Response code: 0/2 none, 1 short, 3 long |
| data_cmd_i | input | 1 | Command is tied to a data transfer |
| cmd_i | input | 1 | Command line as received from the card |
| cmd_o | output | 1 | Command line value driven toward the card |
| cmd_oe_o | output | 1 | Command line output enable |
| busy_o | output | 1 | Command path active |
| sent_o | output | 1 | Command frame fully sent |
| resp_ok_o | output | 1 | Response received and accepted |
| crc_fail_o | output | 1 | Short response failed its CRC |
| timeout_o | output | 1 | No response start bit in time |
| stop_xfer_o | output | 1 | Abort pulse toward the data path |
| data_start_o | output | 1 | Data transfer start pulse toward the data path |
| resp_w0_o | output | 32 | Response word 0 (most significant) |
| resp_w1_o | output | 32 | Response word 1 |
| resp_w2_o | output | 32 | Response word 2 |
| resp_w3_o | output | 32 | Response word 3 (least significant) |

## Verification
The bench sweeps all 64 indices and checks every driven bit against an arithmetic CRC7 model. A wrong polynomial, bit order or end-bit timing shows up there as a bit mismatch. The response delay is swept from 0 through 64 samples, so a counter off by one either times out at sample 64 or waits one sample too long. Every response bit that the CRC covers is corrupted in turn: a checker with a truncated span lets one of them through as a good response, or overwrites word 0 with bad data. Long responses and a strobe injected mid-frame carrying index 12 show, respectively, whether the word order is reversed and whether a busy start leaks an abort pulse or restarts the frame.

// File: rtl/sd_cmd_path_pkg.sv
package sd_cmd_path_pkg;
  localparam int IDX_W     = 6;
  localparam int ARG_W     = 32;
  localparam int CRC_W     = 7;
  localparam int HDR_W     = 2 + IDX_W + ARG_W;   // bits covered by CRC
  localparam int FRAME_W   = HDR_W + CRC_W + 1;   // 48
  localparam int LONG_W    = 136;
  localparam int LONG_DATA = 128;
  localparam int WORD_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;  // x^7 + x^3 + 1

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX} cmd_state_e;

  function automatic logic [CRC_W-1:0] crc7_step(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_vec(logic [HDR_W-1:0] v);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = HDR_W - 1; i >= 0; i--) c = crc7_step(c, v[i]);
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7
  import sd_cmd_path_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= crc7_step(crc_o, bit_i);
  end
endmodule

// File: rtl/sd_cmd_shreg.sv
module sd_cmd_shreg #(
  parameter int W = 127
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/sd_cmd_tmo.sv
module sd_cmd_tmo #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sd_cmd_path.sv
module sd_cmd_path
  import sd_cmd_path_pkg::*;
#(
  parameter int TMO_CYC  = 64,
  parameter int STOP_IDX = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic [1:0]        resp_code_i,
  input  logic              data_cmd_i,
  input  logic              cmd_i,
  output logic              cmd_o,
  output logic              cmd_oe_o,
  output logic              busy_o,
  output logic              sent_o,
  output logic              resp_ok_o,
  output logic              crc_fail_o,
  output logic              timeout_o,
  output logic              stop_xfer_o,
  output logic              data_start_o,
  output logic [WORD_W-1:0] resp_w0_o,
  output logic [WORD_W-1:0] resp_w1_o,
  output logic [WORD_W-1:0] resp_w2_o,
  output logic [WORD_W-1:0] resp_w3_o
);
  localparam int TXC_W = $clog2(FRAME_W);
  localparam int RXC_W = $clog2(LONG_W);
  localparam int SH_W  = LONG_DATA - 1;
  localparam logic [TXC_W-1:0] TX_LAST    = TXC_W'(FRAME_W - 1);
  localparam logic [RXC_W-1:0] SHORT_LAST = RXC_W'(FRAME_W - 1);
  localparam logic [RXC_W-1:0] LONG_LAST  = RXC_W'(LONG_W - 1);
  localparam logic [RXC_W-1:0] CRC_END    = RXC_W'(HDR_W);
  localparam logic [IDX_W-1:0] STOP_CODE  = IDX_W'(STOP_IDX);

  cmd_state_e          state_q;
  logic [FRAME_W-1:0]  tx_sr_q;
  logic [TXC_W-1:0]    tx_cnt_q;
  logic [RXC_W-1:0]    rx_cnt_q;
  logic                want_q, long_q, data_q;
  logic [FRAME_W-1:0]  frame_d;
  logic [LONG_DATA-1:0] rx_nxt;
  logic [SH_W-1:0]     sh_q;
  logic [CRC_W-1:0]    crc_q;
  logic                tmo_exp;
  logic                rx_last;

  assign frame_d = {2'b01, idx_i, arg_i, crc7_vec({2'b01, idx_i, arg_i}), 1'b1};
  assign rx_nxt  = {sh_q, cmd_i};
  assign rx_last = (rx_cnt_q == (long_q ? LONG_LAST : SHORT_LAST));

  sd_cmd_crc7 i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_WAIT),
    .en_i   ((state_q == ST_RX) && (rx_cnt_q < CRC_END)),
    .bit_i  (cmd_i),
    .crc_o  (crc_q)
  );

  sd_cmd_shreg #(.W(SH_W)) i_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_RX),
    .bit_i  (cmd_i),
    .q_o    (sh_q)
  );

  sd_cmd_tmo #(.LIMIT(TMO_CYC)) i_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_WAIT),
    .expire_o (tmo_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      tx_sr_q      <= '0;
      tx_cnt_q     <= '0;
      rx_cnt_q     <= '0;
      want_q       <= 1'b0;
      long_q       <= 1'b0;
      data_q       <= 1'b0;
      sent_o       <= 1'b0;
      resp_ok_o    <= 1'b0;
      crc_fail_o   <= 1'b0;
      timeout_o    <= 1'b0;
      stop_xfer_o  <= 1'b0;
      data_start_o <= 1'b0;
      resp_w0_o    <= '0;
      resp_w1_o    <= '0;
      resp_w2_o    <= '0;
      resp_w3_o    <= '0;
    end else begin
      stop_xfer_o  <= 1'b0;
      data_start_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tx_sr_q     <= frame_d;
          tx_cnt_q    <= '0;
          want_q      <= resp_code_i[0];
          long_q      <= resp_code_i[1];
          data_q      <= data_cmd_i;
          sent_o      <= 1'b0;
          resp_ok_o   <= 1'b0;
          crc_fail_o  <= 1'b0;
          timeout_o   <= 1'b0;
          stop_xfer_o <= (idx_i == STOP_CODE);
          state_q     <= ST_TX;
        end
        ST_TX: begin
          tx_sr_q <= {tx_sr_q[FRAME_W-2:0], 1'b1};
          if (tx_cnt_q == TX_LAST) begin
            sent_o <= 1'b1;
            if (want_q) state_q <= ST_WAIT;
            else begin
              state_q      <= ST_IDLE;
              data_start_o <= data_q;
            end
          end else begin
            tx_cnt_q <= tx_cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (!cmd_i) begin
            rx_cnt_q <= RXC_W'(1);
            state_q  <= ST_RX;
          end else if (tmo_exp) begin
            timeout_o <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_RX: begin
          if (rx_last) begin
            state_q <= ST_IDLE;
            if (long_q) begin
              {resp_w0_o, resp_w1_o, resp_w2_o, resp_w3_o} <= rx_nxt;
              resp_ok_o    <= 1'b1;
              data_start_o <= data_q;
            end else if (crc_q == rx_nxt[CRC_W:1]) begin
              resp_w0_o    <= rx_nxt[HDR_W-1:CRC_W+1];
              resp_ok_o    <= 1'b1;
              data_start_o <= data_q;
            end else begin
              crc_fail_o <= 1'b1;
            end
          end else begin
            rx_cnt_q <= rx_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_oe_o = (state_q == ST_TX);
  assign cmd_o    = cmd_oe_o ? tx_sr_q[FRAME_W-1] : 1'b1;
  assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/sd_cmd_path_chk.sv
module sd_cmd_path_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cmd_o,
  input logic cmd_oe_o,
  input logic busy_o,
  input logic sent_o,
  input logic resp_ok_o,
  input logic crc_fail_o,
  input logic timeout_o,
  input logic stop_xfer_o,
  input logic data_start_o
);
  // R4
  resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({resp_ok_o, crc_fail_o, timeout_o}));

  // R1
  idle_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_oe_o |-> cmd_o);

  // R1
  drive_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_oe_o |-> busy_o);

  // R3
  sent_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sent_o) |-> ($past(cmd_oe_o) && $past(cmd_o) && !cmd_oe_o));

  // R7
  stop_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_xfer_o |-> ($past(start_i) && !$past(busy_o)));

  // R8
  dstart_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_start_o |-> (!crc_fail_o && !timeout_o && !busy_o));

  // R4
  tmo_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (!busy_o && !cmd_oe_o));

  // R9
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && cmd_oe_o));
endmodule

bind sd_cmd_path sd_cmd_path_chk i_sd_cmd_path_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .cmd_o        (cmd_o),
  .cmd_oe_o     (cmd_oe_o),
  .busy_o       (busy_o),
  .sent_o       (sent_o),
  .resp_ok_o    (resp_ok_o),
  .crc_fail_o   (crc_fail_o),
  .timeout_o    (timeout_o),
  .stop_xfer_o  (stop_xfer_o),
  .data_start_o (data_start_o)
);

// File: tb/test_sd_cmd_path.sv
`timescale 1ns/1ps
module test_sd_cmd_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  idx = '0;
  logic [31:0] arg = '0;
  logic [1:0]  code = '0;
  logic        dcmd = 1'b0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, busy, sent, rok, cfail, tmo, stopx, dstart;
  logic [31:0] w0, w1, w2, w3;

  always #2.5 clk = ~clk;

  sd_cmd_path i_sd_cmd_path (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .idx_i(idx), .arg_i(arg),
    .resp_code_i(code), .data_cmd_i(dcmd), .cmd_i(cmd_in),
    .cmd_o(cmd_out), .cmd_oe_o(cmd_oe), .busy_o(busy), .sent_o(sent),
    .resp_ok_o(rok), .crc_fail_o(cfail), .timeout_o(tmo),
    .stop_xfer_o(stopx), .data_start_o(dstart),
    .resp_w0_o(w0), .resp_w1_o(w1), .resp_w2_o(w2), .resp_w3_o(w3)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit fin = 1'b0;
  logic [31:0] ew [4];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] ref_crc(input logic [39:0] v);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  task automatic chk_words(input string req);
    chk({w0, w1, w2, w3} == {ew[0], ew[1], ew[2], ew[3]}, req,
        {w0, w1, w2, w3}, {ew[0], ew[1], ew[2], ew[3]});
  endtask

  task automatic run(input logic [5:0] c_idx, input logic [31:0] c_arg, input logic [1:0] c_code,
                     input bit dflag, input int dly, input logic [127:0] pay, input int corrupt,
                     input bit poke);
    logic [47:0]  fr;
    logic [135:0] rf;
    int           len;
    bit           ok;
    fr = {2'b01, c_idx, c_arg, ref_crc({2'b01, c_idx, c_arg}), 1'b1};
    @(negedge clk);
    start = 1'b1; idx = c_idx; arg = c_arg; code = c_code; dcmd = dflag;
    @(negedge clk);
    start = 1'b0; idx = ~c_idx; arg = ~c_arg; code = ~c_code; dcmd = ~dflag;
    chk(stopx == (c_idx == 6'd12), "R7 stop pulse", stopx, c_idx == 6'd12);
    chk(!sent && !rok && !cfail && !tmo, "R9 flags cleared", {sent, rok, cfail, tmo}, 0);
    for (int k = 0; k < 48; k++) begin
      chk(cmd_out == fr[47-k] && cmd_oe, "R1 frame bit", {cmd_oe, cmd_out}, {1'b1, fr[47-k]});
      if (k == 1) chk(!stopx, "R7 one cycle", stopx, 0);
      if (poke && k == 5) begin start = 1'b1; idx = 6'd12; code = 2'd0; end
      if (poke && k == 6) begin
        start = 1'b0;
        chk(!stopx && busy, "R9 busy start ignored", {busy, stopx}, 2'b10);
      end
      @(negedge clk);
    end
    chk(sent && !cmd_oe && cmd_out, "R3 sent after end bit", {sent, cmd_oe, cmd_out}, 3'b101);
    if (!c_code[0]) begin
      chk(!busy, "R2 no-response done", busy, 0);
      chk(dstart == dflag, "R8 data start no-resp", dstart, dflag);
      chk(!rok && !cfail && !tmo, "R2 no response flags", {rok, cfail, tmo}, 0);
      chk_words("R2 words kept");
      return;
    end
    chk(busy && !rok && !cfail && !tmo, "R3 still busy", {busy, rok, cfail, tmo}, 4'b1000);
    if (dly >= 64) begin
      for (int t = 0; t < 64; t++) begin
        cmd_in = 1'b1;
        @(negedge clk);
        if (t == 62) chk(busy && !tmo, "R4 not yet timed out", {busy, tmo}, 2'b10);
      end
      chk(tmo && !busy && !rok && !cfail, "R4 timeout", {tmo, busy, rok, cfail}, 4'b1000);
      chk(!dstart, "R8 no data start on timeout", dstart, 0);
      chk_words("R4 words kept");
      return;
    end
    for (int t = 0; t < dly; t++) begin cmd_in = 1'b1; @(negedge clk); end
    rf = '0;
    if (c_code[1]) begin
      rf = {2'b00, 6'h3F, pay};
      len = 136;
    end else begin
      rf[135:88] = {2'b00, c_idx, pay[31:0], ref_crc({2'b00, c_idx, pay[31:0]}), 1'b1};
      len = 48;
    end
    if (corrupt >= 0) rf[135-corrupt] = ~rf[135-corrupt];
    for (int j = 0; j < len; j++) begin
      cmd_in = rf[135-j];
      @(negedge clk);
      if (j < len - 1) chk(busy, "R3 busy during response", busy, 1);
    end
    cmd_in = 1'b1;
    ok = c_code[1] || (corrupt < 0);
    chk(!busy && rok == ok && cfail == !ok && !tmo, c_code[1] ? "R6 long status" : "R5 short status",
        {busy, rok, cfail, tmo}, {1'b0, ok, !ok, 1'b0});
    chk(dstart == (ok && dflag), "R8 data start on response", dstart, ok && dflag);
    if (ok) begin
      if (c_code[1]) begin
        ew[0] = pay[127:96]; ew[1] = pay[95:64]; ew[2] = pay[63:32]; ew[3] = pay[31:0];
      end else begin
        ew[0] = pay[31:0];
      end
    end
    chk_words(c_code[1] ? "R6 long words" : "R5 short words");
    @(negedge clk);
    chk(!dstart && !stopx, "R8 pulse one cycle", {dstart, stopx}, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) ew[i] = '0;
    #1;
    chk(!busy && !cmd_oe && cmd_out, "R10 reset line", {busy, cmd_oe, cmd_out}, 3'b001);
    chk(!sent && !rok && !cfail && !tmo && !stopx && !dstart, "R10 reset flags",
        {sent, rok, cfail, tmo, stopx, dstart}, 0);
    chk_words("R10 reset words");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // no-response sweep over every index, codes 0 and 2
    for (int i = 0; i < 64; i++)
      run(6'(i), (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000, (i % 2 == 1) ? 2'd2 : 2'd0,
          (i % 3 == 0), 0, '0, -1, (i == 20));
    // short response delay sweep; 64 is a timeout
    for (int d = 0; d <= 64; d++)
      run(6'd13, 32'(d), 2'd1, (d % 2 == 1), d, {4{32'hC0DE0000 + 32'(d) * 32'h00010003}}, -1, 1'b0);
    // every CRC-covered bit corrupted in turn
    for (int c = 1; c <= 46; c++)
      run(6'd17, 32'(c), 2'd1, 1'b1, 3, {96'd0, 32'hA5000000 ^ (32'(c) * 32'h01010101)}, c, 1'b0);
    // long responses
    for (int k = 0; k < 6; k++)
      run(6'(2 + k), 32'(k), 2'd3, (k % 2 == 0), k * 7,
          {32'h01234567 * 32'(k + 1), 32'h89ABCDEF ^ 32'(k), 32'hFEDC0000 + 32'(k), 32'h13579BDF * 32'(k + 3)},
          -1, 1'b0);
    run(6'd9, 32'h0, 2'd3, 1'b1, 64, '0, -1, 1'b0);
    // stop-transmission with short response and data flag
    run(6'd12, 32'h0, 2'd1, 1'b1, 10, {96'd0, 32'h00000900}, -1, 1'b0);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_vec++;
      n_bad++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule